// File: doc/BRIEF.md
# Power-On Reset and Boot-Mode Sequencer

This block sits between the board-level reset pin and the start-up cores. It watches three core supply-good inputs, two peripheral I/O bank supply-good inputs and an active-low power-on reset pin. The internal reset stays asserted until the pin has been held low for a programmable time while all core supplies are good. On the cycle the internal reset is released, the 4-bit boot-mode pins are sampled once. The value is stored in a read-only power-on copy and in a user copy. Software may later override the user copy with an alternate mode.

After release the sequencer decodes the effective boot mode. If the mode points at a device on a peripheral bank, the sequencer waits for that bank's supply. It then releases the boot controller core. The main processor is released only after the boot controller reports that its firmware load is done.

Any loss of a required supply, or a new low level on the reset pin, sends the sequencer back to the internal reset state. A loss of a core supply also raises an external power-on-reset indication. An undefined boot code raises an error flag and keeps both cores in reset.

Top module: `por_boot_seq`

## Requirements
- R1: After the synchronous reset `rst`, the outputs are: `sys_rst_o`, `bc_rst_o` and `proc_rst_o` are 1, `mode_err_o` is 0, and both registers read 0. `ext_por_o` is 1 while any core supply is low.
- R2: `sys_rst_o` falls after the first clock edge at which `por_n_i` is high, provided `por_n_i` was low with all core supplies good for HOLD_CYC = CLK_MHZ*HOLD_US consecutive edges before that edge. If `por_n_i` rises before that count is reached, the count restarts from zero.
- R3: `ext_por_o` is 1 in the cycle after a clock edge at which any bit of `core_pg_i` is 0. It is 0 after an edge at which all three bits are 1.
- R4: At the release edge, `mode_pins_i` is copied into the power-on register (address 0, bits [3:0]) and into bits [3:0] of the user register (address 1). At that edge, use-alternate (bit 8) and the alternate code (bits [7:4]) are cleared. Pin values at any other time change neither register.
- R5: `eff_mode_o` equals user bits [7:4] when user bit 8 is 1, and user bits [3:0] otherwise.
- R6: Writes to address 0 are ignored. Writes to address 1 update only bits 8:4. They take effect only while `sys_rst_o` is 0.
- R7: Boot code 0 (JTAG) needs no bank supply. Codes 1 and 2 need `bank_pg_i[0]`, and codes 3 and 4 need `bank_pg_i[1]`. After release the sequencer keeps `bc_rst_o` at 1 until the needed bank supply is good. `bc_rst_o` falls after the first edge at which that supply is good.
- R8: While the boot controller runs, `proc_rst_o` falls after the first edge at which `fw_done_i` is 1. The processor is never out of reset while the boot controller is in reset.
- R9: A code from 5 to 15 sets `mode_err_o` after the first edge in the checking phase. Both cores stay in reset while the error flag is set. Changing the effective mode to a defined code lets boot continue.
- R10: After release, any of the following returns the block to internal reset (`sys_rst_o`, `bc_rst_o` and `proc_rst_o` all 1) after the next edge: a core supply going low, `por_n_i` going low, or loss of the bank supply chosen for the running boot. A bank not chosen by the running boot has no effect. The hold count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_n_i | input | 1 | Active-low power-on reset pin, already synchronized |
| core_pg_i | input | 3 | Core supply-good flags |
| bank_pg_i | input | 2 | Peripheral bank 0/1 supply-good flags |
| mode_pins_i | input | 4 | Boot-mode pins |
| fw_done_i | input | 1 | Boot controller reports firmware loaded |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register address: 0 power-on copy, 1 user copy |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for `reg_addr_i` |
| eff_mode_o | output | 4 | Effective boot mode |
| sys_rst_o | output | 1 | Internal reset |
| bc_rst_o | output | 1 | Boot controller reset |
| proc_rst_o | output | 1 | Main processor reset |
| ext_por_o | output | 1 | External power-on-reset indication |
| mode_err_o | output | 1 | Undefined boot code flag |

## Verification
The properties assume the following about the inputs:
- `por_n_i` and the supply-good flags are already synchronous to `clk`.
- `fw_done_i` has meaning only while the boot controller runs.
- Register writes are single-cycle strobes.

The stimulus changes every input 2 ns after a rising edge, so each input is stable through the following edge. Writes are issued as one-cycle pulses. Supply drops last at least one full cycle. This keeps each event visible to the properties that relate a supply or pin level to the reset outputs one edge later.

// File: rtl/por_boot_pkg.sv
package por_boot_pkg;

    localparam int MODE_W = 4;
    localparam int REG_W  = 16;
    localparam int N_CORE = 3;
    localparam int N_BANK = 2;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_CHECK = 2'd1,
        ST_BCRUN = 2'd2,
        ST_PRUN  = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        BK_NONE = 2'd0,
        BK_0    = 2'd1,
        BK_1    = 2'd2,
        BK_BAD  = 2'd3
    } bank_sel_e;

    typedef struct packed {
        logic              use_alt;
        logic [MODE_W-1:0] alt;
        logic [MODE_W-1:0] cap;
    } user_reg_t;

    localparam logic [MODE_W-1:0] MODE_JTAG = 4'd0;
    localparam logic [MODE_W-1:0] MODE_B0_A = 4'd1;
    localparam logic [MODE_W-1:0] MODE_B0_B = 4'd2;
    localparam logic [MODE_W-1:0] MODE_B1_A = 4'd3;
    localparam logic [MODE_W-1:0] MODE_B1_B = 4'd4;

    function automatic bank_sel_e mode_bank(input logic [MODE_W-1:0] code);
        bank_sel_e b;
        case (code)
            MODE_JTAG:            b = BK_NONE;
            MODE_B0_A, MODE_B0_B: b = BK_0;
            MODE_B1_A, MODE_B1_B: b = BK_1;
            default:              b = BK_BAD;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/por_hold_timer.sv
module por_hold_timer #(
    parameter int HOLD_CYC = 1250
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic core_ok,
    input  logic pin_low,
    output logic met
);
    localparam int CNT_W = $clog2(HOLD_CYC + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(HOLD_CYC);

    logic [CNT_W-1:0] cnt_q;

    assign met = (cnt_q == LIMIT);

    always_ff @(posedge clk) begin
        if (rst || !arm || !core_ok) begin
            cnt_q <= '0;
        end else if (pin_low) begin
            if (!met) cnt_q <= cnt_q + 1'b1;
        end else if (!met) begin
            cnt_q <= '0;
        end
    end
endmodule

// File: rtl/bootmode_regs.sv
module bootmode_regs
    import por_boot_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [MODE_W-1:0] pins,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic [MODE_W-1:0] eff_mode,
    output logic [MODE_W-1:0] por_mode
);
    localparam int USER_W = $bits(user_reg_t);

    logic [MODE_W-1:0] por_q;
    user_reg_t         user_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            por_q  <= '0;
            user_q <= '0;
        end else if (capture) begin
            por_q          <= pins;
            user_q.cap     <= pins;
            user_q.alt     <= '0;
            user_q.use_alt <= 1'b0;
        end else if (wr_en && addr) begin
            user_q.alt     <= wdata[2*MODE_W-1:MODE_W];
            user_q.use_alt <= wdata[2*MODE_W];
        end
    end

    always_comb begin
        rdata = '0;
        if (addr) rdata[USER_W-1:0] = user_q;
        else      rdata[MODE_W-1:0] = por_q;
    end

    assign eff_mode = user_q.use_alt ? user_q.alt : user_q.cap;
    assign por_mode = por_q;
endmodule

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
    import por_boot_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              core_ok,
    input  logic              por_n,
    input  logic [N_BANK-1:0] bank_ok,
    input  logic              hold_met,
    input  logic [MODE_W-1:0] eff_mode,
    input  logic              fw_done,
    output seq_state_e        state,
    output logic              capture,
    output logic              mode_err,
    output logic              ext_por
);
    seq_state_e state_q, nxt;
    bank_sel_e  run_bank_q, cur_bank;
    logic       err_q, ext_q;
    logic       bank_loss, loss, bank_ready, bad;

    assign cur_bank = mode_bank(eff_mode);
    assign bad      = (cur_bank == BK_BAD);

    always_comb begin
        case (cur_bank)
            BK_NONE: bank_ready = 1'b1;
            BK_0:    bank_ready = bank_ok[0];
            BK_1:    bank_ready = bank_ok[1];
            default: bank_ready = 1'b0;
        endcase
    end

    assign bank_loss = ((run_bank_q == BK_0) && !bank_ok[0]) ||
                       ((run_bank_q == BK_1) && !bank_ok[1]);
    assign loss      = !core_ok || !por_n || bank_loss;

    always_comb begin
        nxt     = state_q;
        capture = 1'b0;
        if (state_q == ST_HOLD) begin
            if (por_n && core_ok && hold_met) begin
                nxt     = ST_CHECK;
                capture = 1'b1;
            end
        end else if (loss) begin
            nxt = ST_HOLD;
        end else begin
            case (state_q)
                ST_CHECK: if (!bad && bank_ready) nxt = ST_BCRUN;
                ST_BCRUN: if (fw_done) nxt = ST_PRUN;
                default:  nxt = state_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_HOLD;
            run_bank_q <= BK_NONE;
            err_q      <= 1'b0;
            ext_q      <= 1'b1;
        end else begin
            state_q <= nxt;
            ext_q   <= !core_ok;
            err_q   <= (state_q == ST_CHECK) && !loss && bad;
            if (nxt == ST_HOLD)
                run_bank_q <= BK_NONE;
            else if (state_q == ST_CHECK && nxt == ST_BCRUN)
                run_bank_q <= cur_bank;
        end
    end

    assign state    = state_q;
    assign mode_err = err_q;
    assign ext_por  = ext_q;
endmodule

// File: rtl/por_boot_seq.sv
module por_boot_seq
    import por_boot_pkg::*;
#(
    parameter int CLK_MHZ = 125,
    parameter int HOLD_US = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por_n_i,
    input  logic [N_CORE-1:0] core_pg_i,
    input  logic [N_BANK-1:0] bank_pg_i,
    input  logic [MODE_W-1:0] mode_pins_i,
    input  logic              fw_done_i,
    input  logic              reg_wr_i,
    input  logic              reg_addr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    output logic [MODE_W-1:0] eff_mode_o,
    output logic              sys_rst_o,
    output logic              bc_rst_o,
    output logic              proc_rst_o,
    output logic              ext_por_o,
    output logic              mode_err_o
);
    localparam int HOLD_CYC = CLK_MHZ * HOLD_US;

    seq_state_e        state;
    logic              core_ok, hold_met, capture;
    logic [MODE_W-1:0] por_mode_w;

    assign core_ok = &core_pg_i;

    por_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .arm     (state == ST_HOLD),
        .core_ok (core_ok),
        .pin_low (!por_n_i),
        .met     (hold_met)
    );

    bootmode_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .capture  (capture),
        .pins     (mode_pins_i),
        .wr_en    (reg_wr_i && (state != ST_HOLD)),
        .addr     (reg_addr_i),
        .wdata    (reg_wdata_i),
        .rdata    (reg_rdata_o),
        .eff_mode (eff_mode_o),
        .por_mode (por_mode_w)
    );

    boot_seq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .core_ok  (core_ok),
        .por_n    (por_n_i),
        .bank_ok  (bank_pg_i),
        .hold_met (hold_met),
        .eff_mode (eff_mode_o),
        .fw_done  (fw_done_i),
        .state    (state),
        .capture  (capture),
        .mode_err (mode_err_o),
        .ext_por  (ext_por_o)
    );

    assign sys_rst_o  = (state == ST_HOLD);
    assign bc_rst_o   = (state == ST_HOLD) || (state == ST_CHECK);
    assign proc_rst_o = (state != ST_PRUN);
endmodule

// File: rtl/por_boot_seq_chk.sv
module por_boot_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       por_n_i,
    input logic [2:0] core_pg_i,
    input logic       sys_rst_o,
    input logic       bc_rst_o,
    input logic       proc_rst_o,
    input logic       ext_por_o,
    input logic       mode_err_o,
    input logic [3:0] por_mode_w
);
    a_r3_ext_por_raised: assert property (@(posedge clk) disable iff (rst)
        (core_pg_i != 3'b111) |=> ext_por_o);

    a_r2_pin_low_holds: assert property (@(posedge clk) disable iff (rst)
        (sys_rst_o && !por_n_i) |=> sys_rst_o);

    a_r10_loss_to_hold: assert property (@(posedge clk) disable iff (rst)
        (!sys_rst_o && ((core_pg_i != 3'b111) || !por_n_i)) |=> sys_rst_o);

    a_r8_proc_after_bc: assert property (@(posedge clk) disable iff (rst)
        !proc_rst_o |-> !bc_rst_o);

    a_r9_err_holds_cores: assert property (@(posedge clk) disable iff (rst)
        mode_err_o |-> (bc_rst_o && proc_rst_o && !sys_rst_o));

    a_r4_por_copy_stable: assert property (@(posedge clk) disable iff (rst)
        !$fell(sys_rst_o) |-> $stable(por_mode_w));
endmodule

bind por_boot_seq por_boot_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .por_n_i    (por_n_i),
    .core_pg_i  (core_pg_i),
    .sys_rst_o  (sys_rst_o),
    .bc_rst_o   (bc_rst_o),
    .proc_rst_o (proc_rst_o),
    .ext_por_o  (ext_por_o),
    .mode_err_o (mode_err_o),
    .por_mode_w (por_mode_w)
);

// File: tb/por_boot_seq_test.sv
module por_boot_seq_test;
    localparam int HOLD = 125 * 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        por_n = 1'b0;
    logic [2:0]  core_pg = 3'b000;
    logic [1:0]  bank_pg = 2'b00;
    logic [3:0]  pins = 4'd0;
    logic        fw_done = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [3:0]  eff_mode;
    logic        sys_rst, bc_rst, proc_rst, ext_por, mode_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit started = 0;

    always #4 clk = ~clk;

    por_boot_seq uut (
        .clk(clk), .rst(rst), .por_n_i(por_n), .core_pg_i(core_pg),
        .bank_pg_i(bank_pg), .mode_pins_i(pins), .fw_done_i(fw_done),
        .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .eff_mode_o(eff_mode), .sys_rst_o(sys_rst),
        .bc_rst_o(bc_rst), .proc_rst_o(proc_rst), .ext_por_o(ext_por),
        .mode_err_o(mode_err)
    );

    // behavioural reference: 0 hold, 1 check, 2 boot ctrl, 3 processor
    int m_st, m_cnt, m_por, m_cap, m_alt, m_use, m_err, m_ext, m_run;

    function automatic int bank_of(input int c);
        if (c == 0) return -1;
        if (c == 1 || c == 2) return 0;
        if (c == 3 || c == 4) return 1;
        return -2;
    endfunction

    always @(posedge clk) begin : model
        int o_st, o_eff, bk;
        bit coreok, loss;
        if (rst) begin
            m_st = 0; m_cnt = 0; m_por = 0; m_cap = 0; m_alt = 0;
            m_use = 0; m_err = 0; m_ext = 1; m_run = -1; started = 1;
        end else begin
            coreok = (core_pg == 3'b111);
            o_st   = m_st;
            o_eff  = m_use ? m_alt : m_cap;
            m_ext  = coreok ? 0 : 1;
            if (o_st != 0 && reg_wr && reg_addr) begin
                m_use = int'(reg_wdata[8]);
                m_alt = int'(reg_wdata[7:4]);
            end
            if (o_st == 0) begin
                m_err = 0;
                if (!coreok) m_cnt = 0;
                else if (!por_n) begin
                    if (m_cnt < HOLD) m_cnt++;
                end else if (m_cnt == HOLD) begin
                    m_st = 1; m_cnt = 0; m_por = int'(pins); m_cap = int'(pins);
                    m_use = 0; m_alt = 0;
                end else m_cnt = 0;
            end else begin
                loss = !coreok || !por_n || (m_run == 0 && !bank_pg[0]) ||
                       (m_run == 1 && !bank_pg[1]);
                if (loss) begin
                    m_st = 0; m_cnt = 0; m_err = 0; m_run = -1;
                end else if (o_st == 1) begin
                    bk = bank_of(o_eff);
                    if (bk == -2) m_err = 1;
                    else begin
                        m_err = 0;
                        if (bk == -1 || bank_pg[bk] == 1'b1) begin
                            m_st = 2; m_run = bk;
                        end
                    end
                end else if (o_st == 2 && fw_done) m_st = 3;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !rst && !done) begin
            chk("R2 model sys_rst", int'(sys_rst), (m_st == 0) ? 1 : 0);
            chk("R7 model bc_rst", int'(bc_rst), (m_st < 2) ? 1 : 0);
            chk("R8 model proc_rst", int'(proc_rst), (m_st != 3) ? 1 : 0);
            chk("R3 model ext_por", int'(ext_por), m_ext);
            chk("R9 model mode_err", int'(mode_err), m_err);
            chk("R5 model eff_mode", int'(eff_mode), m_use ? m_alt : m_cap);
            chk("R4 model rdata", int'(reg_rdata),
                reg_addr ? ((m_use << 8) | (m_alt << 4) | m_cap) : m_por);
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic rd(input bit a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic wr(input bit a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step(1);
        reg_wr = 1'b0;
    endtask

    task automatic boot(input logic [3:0] code);
        core_pg = 3'b111; por_n = 1'b0; pins = code;
        step(HOLD + 1);
        por_n = 1'b1;
        step(1);
    endtask

    initial begin : stim
        int v;
        step(3);
        rst = 1'b0;
        step(1);
        // R1 reset state
        chk("R1 sys_rst", int'(sys_rst), 1);
        chk("R1 bc_rst", int'(bc_rst), 1);
        chk("R1 proc_rst", int'(proc_rst), 1);
        chk("R1 ext_por", int'(ext_por), 1);
        chk("R1 mode_err", int'(mode_err), 0);
        rd(0, v); chk("R1 por reg", v, 0);
        rd(1, v); chk("R1 user reg", v, 0);

        // R2 early release and exact boundary, JTAG code
        core_pg = 3'b111; pins = 4'd0;
        step(100);
        chk("R3 ext_por clears", int'(ext_por), 0);
        por_n = 1'b1; step(5);
        chk("R2 early release held", int'(sys_rst), 1);
        por_n = 1'b0; step(HOLD - 1);
        por_n = 1'b1; step(1);
        chk("R2 one short held", int'(sys_rst), 1);
        por_n = 1'b0; step(HOLD);
        por_n = 1'b1; step(1);
        chk("R2 released at count", int'(sys_rst), 0);
        step(1);
        chk("R7 jtag no bank needed", int'(bc_rst), 0);
        chk("R8 proc held", int'(proc_rst), 1);
        fw_done = 1'b1; step(1); fw_done = 1'b0;
        chk("R8 proc released", int'(proc_rst), 0);

        // R4 pins ignored after capture
        pins = 4'd9; step(5);
        rd(0, v); chk("R4 por reg unchanged", v, 0);
        rd(1, v); chk("R4 user reg unchanged", v, 0);

        // R6 and R5 register access
        wr(0, 16'hFFFF);
        rd(0, v); chk("R6 por reg write ignored", v, 0);
        wr(1, 16'h013F);
        rd(1, v); chk("R6 user write bits 8:4", v, 16'h0130);
        chk("R5 alternate selected", int'(eff_mode), 3);

        // R10 pin low returns to hold; writes ignored there
        por_n = 1'b0; step(1);
        chk("R10 pin low sys_rst", int'(sys_rst), 1);
        chk("R10 pin low proc_rst", int'(proc_rst), 1);
        wr(1, 16'h0000);
        rd(1, v); chk("R6 write in hold ignored", v, 16'h0130);

        // R7 bank 0 device waits for its supply
        bank_pg = 2'b00;
        boot(4'd2);
        rd(0, v); chk("R4 por capture", v, 2);
        rd(1, v); chk("R4 user capture clears alt", v, 2);
        step(1);
        chk("R7 waits bank0", int'(bc_rst), 1);
        bank_pg = 2'b01; step(1);
        chk("R7 bank0 good releases", int'(bc_rst), 0);
        bank_pg = 2'b00; step(1);
        chk("R10 chosen bank loss", int'(sys_rst), 1);

        // R10 unrelated bank has no effect
        bank_pg = 2'b10;
        boot(4'd3);
        step(1);
        chk("R7 bank1 boot", int'(bc_rst), 0);
        bank_pg = 2'b11; step(1);
        bank_pg = 2'b10; step(1);
        chk("R10 other bank ignored", int'(bc_rst), 0);

        // R3 core supply drop
        core_pg = 3'b101; step(1);
        chk("R3 ext_por on drop", int'(ext_por), 1);
        chk("R10 core drop sys_rst", int'(sys_rst), 1);
        core_pg = 3'b111; step(1);
        chk("R3 ext_por off", int'(ext_por), 0);

        // R9 undefined code, then recovery through alternate mode
        boot(4'd7);
        step(1);
        chk("R9 err set", int'(mode_err), 1);
        chk("R9 bc held", int'(bc_rst), 1);
        chk("R9 proc held", int'(proc_rst), 1);
        wr(1, 16'h0100);
        step(1);
        chk("R9 recovered bc", int'(bc_rst), 0);
        chk("R9 err cleared", int'(mode_err), 0);
        chk("R5 eff from alt", int'(eff_mode), 0);

        step(3);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule